// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block is the receive half of a start-stop serial channel. It watches one serial input line, finds the start of each frame, and samples every following bit at the middle of its bit period. It then rebuilds the data word and hands it to the surrounding logic together with a one-cycle completion pulse.

Run-time inputs select the word length (5, 7 or 8 bits), the parity handling, the order in which data bits arrive and the idle level of the line. The bit period is derived from the operating clock and a 7-bit divisor field. Three sticky error flags record framing, parity and overrun faults until a clear strobe removes them. Any faulty word also raises a separate error pulse alongside the completion pulse.

The configuration inputs must be held stable while a frame is being received. The read acknowledge input tells the receiver that the current word has been taken.

Top module: `serial_rx_channel`

## Requirements
- R1: During and after a synchronous reset, `rx_data` is 0 and `rx_done`, `err_pulse` and all three flags are low.
- R2: An 8-bit frame sent least significant bit first with no parity appears on `rx_data`, together with a `rx_done` pulse that lasts exactly one cycle.
- R3: `cfg_len` selects the word length: 0 gives 5 bits, 1 gives 7 bits, and 2 or 3 give 8 bits. Shorter words are right-aligned in `rx_data` and the unused upper bits are 0.
- R4: With `cfg_msb_first`=1, the first data bit received becomes the most significant bit of the word.
- R5: With `cfg_invert`=1, the idle line is low and every line level is complemented before it is decoded.
- R6: `cfg_parity` 2 selects even parity and 3 selects odd parity. With either, a parity bit that does not match the data sets `flag_parity`.
- R7: `cfg_parity` 1 expects a parity bit but never checks it. `cfg_parity` 0 expects no parity bit.
- R8: A stop bit sampled low sets `flag_frame`. The word is still delivered.
- R9: If a word completes while the previous word has not been acknowledged through `rd_ack`, `flag_overrun` is set and the new word replaces the old one.
- R10: A falling edge whose line is high again at the middle of the start bit is discarded. It produces no `rx_done`, no `err_pulse` and no flag.
- R11: The flags stay set until `err_clr` is applied. If `err_clr` arrives in the same cycle as a new error, the flag stays set.
- R12: With divisor N (N ≥ 2), one bit lasts 2·(N+1) clocks. With the default two synchronizer stages, `rx_done` is high in cycle 4 + N + (bits+1)·2·(N+1) after the cycle in which the line falls. Here bits counts the data bits plus the parity bit, if any.
- R13: `err_pulse` is high only in a `rx_done` cycle, and only when that word has a framing, parity or overrun error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial input line |
| cfg_len | input | 2 | Word length code (0:5, 1:7, 2/3:8 bits) |
| cfg_parity | input | 2 | Parity mode (0 none, 1 zero-unchecked, 2 even, 3 odd) |
| cfg_msb_first | input | 1 | 1: first data bit is the most significant bit |
| cfg_invert | input | 1 | 1: line idles low and is complemented |
| cfg_div | input | 7 | Bit-rate divisor N, bit period 2·(N+1) clocks |
| rd_ack | input | 1 | Current word has been read |
| err_clr | input | 1 | Clears the sticky error flags |
| rx_data | output | 8 | Last received word |
| rx_done | output | 1 | One-cycle word-complete pulse |
| err_pulse | output | 1 | One-cycle pulse for a faulty word |
| flag_frame | output | 1 | Sticky framing error |
| flag_parity | output | 1 | Sticky parity error |
| flag_overrun | output | 1 | Sticky overrun error |

## Verification
Some properties are checked on every cycle. These are the single-cycle width of the completion pulse, the tie between the error pulse and completion, the retention of a set flag while no clear is applied, and the overrun flag following an unacknowledged word. The bit-index range, the parity state only being entered with parity enabled, the divisor minimum and the bound on the bit counter are also checked every cycle. Other behaviour only shows up in the directed scenarios. This covers the correct assembly of words across lengths, bit orders and polarities, and the parity verdicts. It also covers the rejection of a short glitch, the clear-versus-set collision, and the exact completion cycle at two divisors.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int unsigned SRX_WMAX  = 8;
    localparam int unsigned SRX_IDX_W = $clog2(SRX_WMAX);

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_ZERO = 2'd1,
        PAR_EVEN = 2'd2,
        PAR_ODD  = 2'd3
    } par_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [SRX_WMAX-1:0] word;
        logic                frm_err;
        logic                par_err;
    } frame_t;

    function automatic logic [3:0] len_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd5;
            2'd1:    return 4'd7;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/srx_line_cond.sv
module srx_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    input  logic invert,
    output logic bit_q,
    output logic fall
);
    logic [SYNC_STAGES:0] chain;
    logic                 prev_q;

    assign chain[0] = line_in ^ invert;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) chain[g+1] <= 1'b1;
            else     chain[g+1] <= chain[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= chain[SYNC_STAGES];
    end

    assign bit_q = chain[SYNC_STAGES];
    assign fall  = prev_q & ~bit_q;

endmodule

// File: rtl/srx_bit_timer.sv
module srx_bit_timer #(
    parameter int DIV_W   = 7,
    parameter int DIV_MIN = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             load,
    input  logic             half,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;

    assign reload = half ? {1'b0, div} : {div, 1'b1};

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= reload;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign tick = run && (cnt_q == '0);

    assert_div_min_R12: assert property (@(posedge clk) disable iff (rst)
        run |-> (div >= DIV_MIN[DIV_W-1:0]));

    assert_cnt_bound_R12: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= {div, 1'b1});

endmodule

// File: rtl/srx_frame_ctl.sv
module srx_frame_ctl
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_q,
    input  logic       fall,
    input  logic       tick,
    input  logic [1:0] len_code,
    input  par_e       par_mode,
    input  logic       msb_first,
    output logic       run,
    output logic       load,
    output logic       half,
    output logic       fin,
    output frame_t     res
);
    rx_state_e              state_q, state_d;
    logic [SRX_WMAX-1:0]    word_q;
    logic [SRX_IDX_W-1:0]   idx_q;
    logic                   ones_q;
    logic                   par_err_q;
    logic [3:0]             nbits;
    logic                   last_bit;
    logic [SRX_IDX_W-1:0]   pos;
    logic                   par_total;

    assign nbits     = len_bits(len_code);
    assign last_bit  = ({1'b0, idx_q} == (nbits - 4'd1));
    assign pos       = msb_first ? SRX_IDX_W'(nbits - 4'd1 - {1'b0, idx_q}) : idx_q;
    assign par_total = ones_q ^ bit_q;
    assign run       = (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        half    = 1'b0;
        fin     = 1'b0;
        case (state_q)
            ST_IDLE: if (fall) begin
                state_d = ST_START;
                load    = 1'b1;
                half    = 1'b1;
            end
            ST_START: if (tick) begin
                if (bit_q) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_DATA;
                    load    = 1'b1;
                end
            end
            ST_DATA: if (tick) begin
                load = 1'b1;
                if (last_bit) state_d = (par_mode == PAR_NONE) ? ST_STOP : ST_PAR;
            end
            ST_PAR: if (tick) begin
                load    = 1'b1;
                state_d = ST_STOP;
            end
            ST_STOP: if (tick) begin
                fin     = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            word_q    <= '0;
            idx_q     <= '0;
            ones_q    <= 1'b0;
            par_err_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && fall) begin
                word_q    <= '0;
                idx_q     <= '0;
                ones_q    <= 1'b0;
                par_err_q <= 1'b0;
            end else if (state_q == ST_DATA && tick) begin
                word_q[pos] <= bit_q;
                idx_q       <= idx_q + 1'b1;
                ones_q      <= ones_q ^ bit_q;
            end else if (state_q == ST_PAR && tick) begin
                case (par_mode)
                    PAR_EVEN: par_err_q <= par_total;
                    PAR_ODD:  par_err_q <= ~par_total;
                    default:  par_err_q <= 1'b0;
                endcase
            end
        end
    end

    assign res.word    = word_q;
    assign res.frm_err = ~bit_q;
    assign res.par_err = par_err_q;

    assert_idx_range_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA) |-> ({1'b0, idx_q} < nbits));

    assert_par_state_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PAR) |-> (par_mode != PAR_NONE));

    assert_false_start_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_START && tick && bit_q) |=> (state_q == ST_IDLE && !fin));

endmodule

// File: rtl/srx_result_reg.sv
module srx_result_reg
    import srx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                fin,
    input  frame_t              res,
    input  logic                rd_ack,
    input  logic                err_clr,
    output logic [SRX_WMAX-1:0] rx_data,
    output logic                rx_done,
    output logic                err_pulse,
    output logic                flag_frame,
    output logic                flag_parity,
    output logic                flag_overrun
);
    logic unread_q;
    logic new_frm, new_par, new_ovr;

    assign new_frm = fin & res.frm_err;
    assign new_par = fin & res.par_err;
    assign new_ovr = fin & unread_q & ~rd_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data      <= '0;
            rx_done      <= 1'b0;
            err_pulse    <= 1'b0;
            flag_frame   <= 1'b0;
            flag_parity  <= 1'b0;
            flag_overrun <= 1'b0;
            unread_q     <= 1'b0;
        end else begin
            rx_done   <= fin;
            err_pulse <= new_frm | new_par | new_ovr;
            if (fin) rx_data <= res.word;
            if (fin)         unread_q <= 1'b1;
            else if (rd_ack) unread_q <= 1'b0;
            flag_frame   <= (flag_frame   & ~err_clr) | new_frm;
            flag_parity  <= (flag_parity  & ~err_clr) | new_par;
            flag_overrun <= (flag_overrun & ~err_clr) | new_ovr;
        end
    end

    assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> !rx_done);

    assert_err_with_done_R13: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> rx_done);

    assert_overrun_set_R9: assert property (@(posedge clk) disable iff (rst)
        (fin && unread_q && !rd_ack) |=> flag_overrun);

    assert_frame_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (flag_frame && !err_clr) |=> flag_frame);

    assert_parity_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (flag_parity && !err_clr) |=> flag_parity);

endmodule

// File: rtl/serial_rx_channel.sv
module serial_rx_channel
    import srx_pkg::*;
#(
    parameter int DIV_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_line,
    input  logic [1:0]       cfg_len,
    input  logic [1:0]       cfg_parity,
    input  logic             cfg_msb_first,
    input  logic             cfg_invert,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             rd_ack,
    input  logic             err_clr,
    output logic [7:0]       rx_data,
    output logic             rx_done,
    output logic             err_pulse,
    output logic             flag_frame,
    output logic             flag_parity,
    output logic             flag_overrun
);
    logic   bit_q, fall, tick, run, load, half, fin;
    frame_t res;

    srx_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst(rst), .line_in(rx_line), .invert(cfg_invert),
        .bit_q(bit_q), .fall(fall)
    );

    srx_bit_timer #(.DIV_W(DIV_W), .DIV_MIN(2)) u_timer (
        .clk(clk), .rst(rst), .run(run), .load(load), .half(half),
        .div(cfg_div), .tick(tick)
    );

    srx_frame_ctl u_ctl (
        .clk(clk), .rst(rst), .bit_q(bit_q), .fall(fall), .tick(tick),
        .len_code(cfg_len), .par_mode(par_e'(cfg_parity)),
        .msb_first(cfg_msb_first), .run(run), .load(load), .half(half),
        .fin(fin), .res(res)
    );

    srx_result_reg u_res (
        .clk(clk), .rst(rst), .fin(fin), .res(res), .rd_ack(rd_ack),
        .err_clr(err_clr), .rx_data(rx_data), .rx_done(rx_done),
        .err_pulse(err_pulse), .flag_frame(flag_frame),
        .flag_parity(flag_parity), .flag_overrun(flag_overrun)
    );

endmodule

// File: tb/test_serial_rx_channel.sv
`timescale 1ns/1ps
module test_serial_rx_channel;
    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic [1:0] cfg_len = 2'd2;
    logic [1:0] cfg_parity = 2'd0;
    logic       cfg_msb_first = 1'b0;
    logic       cfg_invert = 1'b0;
    logic [6:0] cfg_div = 7'd2;
    logic       rd_ack = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_done, err_pulse, flag_frame, flag_parity, flag_overrun;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int start_cyc = 0;
    int n_done = 0, n_err = 0, done_cyc = 0;
    logic [7:0] last_data = '0;
    logic last_err = 0, last_ff = 0, last_pf = 0, last_of = 0;

    always #2 clk = ~clk;

    serial_rx_channel i_serial_rx_channel (
        .clk(clk), .rst(rst), .rx_line(rx_line), .cfg_len(cfg_len),
        .cfg_parity(cfg_parity), .cfg_msb_first(cfg_msb_first),
        .cfg_invert(cfg_invert), .cfg_div(cfg_div), .rd_ack(rd_ack),
        .err_clr(err_clr), .rx_data(rx_data), .rx_done(rx_done),
        .err_pulse(err_pulse), .flag_frame(flag_frame),
        .flag_parity(flag_parity), .flag_overrun(flag_overrun)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rx_done) begin
            n_done    = n_done + 1;
            n_err     = n_err + int'(err_pulse);
            done_cyc  = cyc;
            last_data = rx_data;
            last_err  = err_pulse;
            last_ff   = flag_frame;
            last_pf   = flag_parity;
            last_of   = flag_overrun;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int nbits_of(input logic [1:0] c);
        return (c == 2'd0) ? 5 : (c == 2'd1) ? 7 : 8;
    endfunction

    function automatic int mask_of(input logic [1:0] c);
        return (1 << nbits_of(c)) - 1;
    endfunction

    task automatic send_frame(input logic [7:0] w, input bit flip_par,
                              input bit bad_stop, input bit zero_val);
        int nb;
        int p;
        logic pb;
        nb = nbits_of(cfg_len);
        p  = 2 * (int'(cfg_div) + 1);
        @(negedge clk);
        rx_line   = 1'b0 ^ cfg_invert;
        start_cyc = cyc;
        repeat (p) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rx_line = (cfg_msb_first ? w[nb-1-i] : w[i]) ^ cfg_invert;
            repeat (p) @(negedge clk);
        end
        if (cfg_parity != 2'd0) begin
            case (cfg_parity)
                2'd1:    pb = zero_val;
                2'd2:    pb = ^(w & 8'(mask_of(cfg_len)));
                default: pb = ~^(w & 8'(mask_of(cfg_len)));
            endcase
            rx_line = (pb ^ flip_par) ^ cfg_invert;
            repeat (p) @(negedge clk);
        end
        rx_line = (bad_stop ? 1'b0 : 1'b1) ^ cfg_invert;
        repeat (p) @(negedge clk);
        rx_line = 1'b1 ^ cfg_invert;
        repeat (2 * p) @(negedge clk);
    endtask

    task automatic ack();
        @(negedge clk); rd_ack = 1'b1;
        @(negedge clk); rd_ack = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] l, input logic [1:0] p,
                           input logic m, input logic inv, input logic [6:0] d);
        @(negedge clk);
        cfg_len = l; cfg_parity = p; cfg_msb_first = m; cfg_div = d;
        cfg_invert = inv; rx_line = 1'b1 ^ inv;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 data", int'(rx_data), 0);
        chk("R1 done", int'(rx_done), 0);
        chk("R1 flags", int'({err_pulse, flag_frame, flag_parity, flag_overrun}), 0);
    endtask

    task automatic t_basic();
        int d0, exp_cyc;
        set_cfg(2'd2, 2'd0, 1'b0, 1'b0, 7'd2);
        d0 = n_done;
        send_frame(8'hA5, 0, 0, 0);
        chk("R2 count", n_done - d0, 1);
        chk("R2 data", int'(last_data), 'hA5);
        chk("R13 no err", int'(last_err), 0);
        exp_cyc = 4 + 2 + 9 * 6;
        chk("R12 timing N=2", done_cyc - start_cyc, exp_cyc);
        ack();
        send_frame(8'h3C, 0, 0, 0);
        chk("R2 data2", int'(last_data), 'h3C);
        chk("R2 no overrun", int'(flag_overrun), 0);
        ack();
    endtask

    task automatic t_lengths();
        set_cfg(2'd0, 2'd0, 1'b0, 1'b0, 7'd3);
        send_frame(8'hF6, 0, 0, 0);
        chk("R3 len5", int'(last_data), 'h16);
        ack();
        set_cfg(2'd1, 2'd0, 1'b0, 1'b0, 7'd3);
        send_frame(8'hD9, 0, 0, 0);
        chk("R3 len7", int'(last_data), 'h59);
        ack();
        set_cfg(2'd3, 2'd0, 1'b0, 1'b0, 7'd3);
        send_frame(8'h81, 0, 0, 0);
        chk("R3 code3 8bit", int'(last_data), 'h81);
        ack();
    endtask

    task automatic t_msb();
        set_cfg(2'd2, 2'd0, 1'b1, 1'b0, 7'd2);
        send_frame(8'hC1, 0, 0, 0);
        chk("R4 msb8", int'(last_data), 'hC1);
        ack();
        set_cfg(2'd0, 2'd0, 1'b1, 1'b0, 7'd2);
        send_frame(8'h13, 0, 0, 0);
        chk("R4 msb5", int'(last_data), 'h13);
        ack();
    endtask

    task automatic t_invert();
        set_cfg(2'd2, 2'd2, 1'b0, 1'b1, 7'd4);
        send_frame(8'h6E, 0, 0, 0);
        chk("R5 inverted data", int'(last_data), 'h6E);
        chk("R5 no error", int'({flag_frame, flag_parity}), 0);
        ack();
    endtask

    task automatic t_parity();
        set_cfg(2'd2, 2'd2, 1'b0, 1'b0, 7'd2);
        send_frame(8'h37, 0, 0, 0);
        chk("R6 even good", int'(flag_parity), 0);
        ack();
        send_frame(8'h37, 1, 0, 0);
        chk("R6 even bad flag", int'(last_pf), 1);
        chk("R13 err pulse parity", int'(last_err), 1);
        ack(); clear_flags();
        set_cfg(2'd1, 2'd3, 1'b0, 1'b0, 7'd2);
        send_frame(8'h55, 0, 0, 0);
        chk("R6 odd good", int'(flag_parity), 0);
        chk("R6 odd data", int'(last_data), 'h55);
        ack();
        send_frame(8'h55, 1, 0, 0);
        chk("R6 odd bad flag", int'(flag_parity), 1);
        ack(); clear_flags();
    endtask

    task automatic t_zero();
        set_cfg(2'd2, 2'd1, 1'b0, 1'b0, 7'd2);
        send_frame(8'h9A, 0, 0, 1);
        chk("R7 zero mode unchecked", int'({last_err, flag_parity, flag_frame}), 0);
        chk("R7 zero mode data", int'(last_data), 'h9A);
        ack();
    endtask

    task automatic t_frame();
        set_cfg(2'd2, 2'd0, 1'b0, 1'b0, 7'd2);
        send_frame(8'h42, 0, 1, 0);
        chk("R8 frame flag", int'(last_ff), 1);
        chk("R8 data kept", int'(last_data), 'h42);
        chk("R13 err pulse frame", int'(last_err), 1);
        repeat (20) @(negedge clk);
        chk("R11 flag held", int'(flag_frame), 1);
        ack(); clear_flags();
        chk("R11 flag cleared", int'(flag_frame), 0);
    endtask

    task automatic t_overrun();
        set_cfg(2'd2, 2'd0, 1'b0, 1'b0, 7'd2);
        send_frame(8'h11, 0, 0, 0);
        send_frame(8'h22, 0, 0, 0);
        chk("R9 overrun flag", int'(last_of), 1);
        chk("R9 overwrite", int'(last_data), 'h22);
        chk("R13 err pulse overrun", int'(last_err), 1);
        ack(); clear_flags();
        send_frame(8'h33, 0, 0, 0);
        chk("R9 no overrun after ack", int'({last_of, last_err}), 0);
        ack();
    endtask

    task automatic t_false_start();
        int d0;
        set_cfg(2'd2, 2'd0, 1'b0, 1'b0, 7'd5);
        d0 = n_done;
        @(negedge clk); rx_line = 1'b0;
        repeat (2) @(negedge clk); rx_line = 1'b1;
        repeat (60) @(negedge clk);
        chk("R10 no done", n_done - d0, 0);
        chk("R10 no flags", int'({flag_frame, flag_parity, flag_overrun}), 0);
        send_frame(8'h7B, 0, 0, 0);
        chk("R10 next word ok", int'(last_data), 'h7B);
        ack();
    endtask

    task automatic t_collide();
        set_cfg(2'd2, 2'd0, 1'b0, 1'b0, 7'd2);
        @(negedge clk); err_clr = 1'b1;
        send_frame(8'h24, 0, 1, 0);
        chk("R11 set wins over clear", int'(last_ff), 1);
        chk("R11 cleared next", int'(flag_frame), 0);
        err_clr = 1'b0;
        ack();
    endtask

    task automatic t_slow();
        set_cfg(2'd1, 2'd2, 1'b1, 1'b0, 7'd20);
        send_frame(8'h4D, 0, 0, 0);
        chk("R12 data N=20", int'(last_data), 'h4D);
        chk("R12 timing N=20", done_cyc - start_cyc, 4 + 20 + 9 * 42);
        ack();
    endtask

    initial begin
        #800000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        t_basic();
        t_lengths();
        t_msb();
        t_invert();
        t_parity();
        t_zero();
        t_frame();
        t_overrun();
        t_false_start();
        t_collide();
        t_slow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule